// File: doc/BRIEF.md
# Smart-Card Parity Error Retry Controller

This block sits on the receive side of a half-duplex smart-card serial line. For each received character it takes a strobe together with the parity check result. When the parity is wrong, it asks the card to send the character again by pulling the shared open-drain I/O line low for one bit time during the guard period. It only drives the output enable, because the pull-down belongs to the pad. Deserialization and bit-clock generation happen elsewhere. The block receives a strobe that pulses once every half bit time.

A run of back-to-back parity errors is counted against a programmable ceiling. While the run is shorter than the ceiling, every bad character is refused. Once the ceiling is reached, refusals stop and a sticky flag reports that the retry budget is spent. A separate suppress input turns the line drive off completely while counting and flagging carry on as usual. Software clears the run counter and the flag together with a single strobe.

Top module: `parity_nack_ctl`

## Requirements
- R1: After reset, nackOe, iterFlag and errCount are all 0.
- R2: A parity-error character (charValid=1, parityErr=1) that arrives while errCount < maxIter increments errCount in the following cycle and schedules one refusal pulse, unless suppressNack=1.
- R3: A scheduled refusal raises nackOe in the cycle after the first halfTick that follows the character cycle. nackOe stays high until the second halfTick after that, then drops in the following cycle. This gives one full bit time of drive.
- R4: A character with good parity (charValid=1, parityErr=0) sets errCount to 0 in the following cycle and starts no refusal.
- R5: A parity-error character that arrives while errCount >= maxIter leaves errCount unchanged, starts no refusal, and sets iterFlag in the following cycle.
- R6: With maxIter = 0, no refusal is ever driven, and the first parity error sets iterFlag.
- R7: While suppressNack=1, no refusal is driven for any character. errCount and iterFlag still follow R2, R4 and R5.
- R8: iterFlag stays set until iterClr=1. iterClr clears errCount and iterFlag in the following cycle, and it takes priority over a character in the same cycle: that character is then discarded and drives no refusal.
- R9: A halfTick that coincides with the character strobe does not count toward the half-bit delay of R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| halfTick | input | 1 | One-cycle strobe every half bit time |
| charValid | input | 1 | One-cycle strobe at the end of each received parity bit |
| parityErr | input | 1 | Parity check result qualified by charValid (1 = bad) |
| maxIter | input | CNT_W | Ceiling on consecutive parity errors that are refused |
| suppressNack | input | 1 | 1 = never drive the refusal pulse |
| iterClr | input | 1 | Clears the error count and the sticky flag |
| nackOe | output | 1 | Open-drain pull-down enable for the I/O line |
| iterFlag | output | 1 | Sticky flag: retry ceiling reached |
| errCount | output | CNT_W | Current count of consecutive parity errors |

## Verification
The assertions rely on three properties of the inputs. No character strobe arrives while a refusal is pending or being driven. maxIter changes only while the count is zero, so the count never sits above the ceiling. The strobes are single-cycle pulses. The directed stimulus respects all three: it lets every refusal window run through three half-bit ticks before presenting the next character, and it reprograms the ceiling only after a clear.

// File: rtl/pnack_pkg.sv
package pnack_pkg;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_LEAD  = 2'd1,
    PH_DRIVE = 2'd2
  } phase_t;

  typedef struct packed {
    logic cntClr;
    logic cntInc;
    logic flagSet;
    logic flagClr;
    logic timerClr;
  } nackStrobes_t;

endpackage

// File: rtl/pnack_dp.sv
module pnack_dp
  import pnack_pkg::*;
#(
  parameter int CNT_W = 3,
  parameter int PH_W  = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             halfTick,
  input  nackStrobes_t     strb,
  output logic [CNT_W-1:0] errCount,
  output logic             iterFlag,
  output logic [PH_W-1:0]  phaseCnt
);

  localparam logic [PH_W-1:0] PH_TOP = {PH_W{1'b1}};

  // consecutive error run length
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             errCount <= '0;
    else if (strb.cntClr)  errCount <= '0;
    else if (strb.cntInc)  errCount <= errCount + CNT_W'(1);
  end

  // sticky ceiling flag
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             iterFlag <= 1'b0;
    else if (strb.flagClr) iterFlag <= 1'b0;
    else if (strb.flagSet) iterFlag <= 1'b1;
  end

  // half-bit counter for the refusal window; a restart wins over a tick
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                phaseCnt <= '0;
    else if (strb.timerClr)                   phaseCnt <= '0;
    else if (halfTick && phaseCnt != PH_TOP)  phaseCnt <= phaseCnt + PH_W'(1);
  end

endmodule

// File: rtl/pnack_ctrl.sv
module pnack_ctrl
  import pnack_pkg::*;
#(
  parameter int CNT_W        = 3,
  parameter int PH_W         = 2,
  parameter int LEAD_HALVES  = 1,
  parameter int DRIVE_HALVES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             halfTick,
  input  logic             charValid,
  input  logic             parityErr,
  input  logic [CNT_W-1:0] maxIter,
  input  logic             suppressNack,
  input  logic             iterClr,
  input  logic [CNT_W-1:0] errCount,
  input  logic [PH_W-1:0]  phaseCnt,
  output nackStrobes_t     strb,
  output logic             nackOe
);

  localparam logic [PH_W-1:0] LEAD_LAST  = PH_W'(LEAD_HALVES - 1);
  localparam logic [PH_W-1:0] DRIVE_LAST = PH_W'(DRIVE_HALVES - 1);

  phase_t phase, phaseNxt;
  logic   badChar, belowCeil, startNack;

  always_comb begin
    badChar   = charValid && parityErr && !iterClr;
    belowCeil = errCount < maxIter;
    startNack = badChar && belowCeil && !suppressNack && (phase == PH_IDLE);

    strb.cntClr  = iterClr || (charValid && !parityErr);
    strb.cntInc  = badChar && belowCeil;
    strb.flagSet = badChar && !belowCeil;
    strb.flagClr = iterClr;
    strb.timerClr = 1'b0;

    phaseNxt = phase;
    unique case (phase)
      PH_IDLE: if (startNack) begin
        phaseNxt      = PH_LEAD;
        strb.timerClr = 1'b1;
      end
      PH_LEAD: if (halfTick && phaseCnt == LEAD_LAST) begin
        phaseNxt      = PH_DRIVE;
        strb.timerClr = 1'b1;
      end
      PH_DRIVE: if (halfTick && phaseCnt == DRIVE_LAST) begin
        phaseNxt = PH_IDLE;
      end
      default: phaseNxt = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) phase <= PH_IDLE;
    else       phase <= phaseNxt;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) nackOe <= 1'b0;
    else       nackOe <= (phaseNxt == PH_DRIVE);
  end

endmodule

// File: rtl/parity_nack_ctl.sv
module parity_nack_ctl
  import pnack_pkg::*;
#(
  parameter int CNT_W        = 3,
  parameter int LEAD_HALVES  = 1,
  parameter int DRIVE_HALVES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             halfTick,
  input  logic             charValid,
  input  logic             parityErr,
  input  logic [CNT_W-1:0] maxIter,
  input  logic             suppressNack,
  input  logic             iterClr,
  output logic             nackOe,
  output logic             iterFlag,
  output logic [CNT_W-1:0] errCount
);

  localparam int SPAN = (LEAD_HALVES > DRIVE_HALVES) ? LEAD_HALVES : DRIVE_HALVES;
  localparam int PH_W = $clog2(SPAN + 1);

  nackStrobes_t    strb;
  logic [PH_W-1:0] phaseCnt;

  pnack_ctrl #(
    .CNT_W(CNT_W), .PH_W(PH_W),
    .LEAD_HALVES(LEAD_HALVES), .DRIVE_HALVES(DRIVE_HALVES)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .halfTick(halfTick),
    .charValid(charValid), .parityErr(parityErr), .maxIter(maxIter),
    .suppressNack(suppressNack), .iterClr(iterClr),
    .errCount(errCount), .phaseCnt(phaseCnt),
    .strb(strb), .nackOe(nackOe)
  );

  pnack_dp #(.CNT_W(CNT_W), .PH_W(PH_W)) u_dp (
    .clk(clk), .rstN(rstN), .halfTick(halfTick), .strb(strb),
    .errCount(errCount), .iterFlag(iterFlag), .phaseCnt(phaseCnt)
  );

endmodule

// File: rtl/pnack_chk.sv
module pnack_chk #(
  parameter int CNT_W = 3
) (
  input logic             clk,
  input logic             rstN,
  input logic             halfTick,
  input logic             charValid,
  input logic             parityErr,
  input logic [CNT_W-1:0] maxIter,
  input logic             suppressNack,
  input logic             iterClr,
  input logic             nackOe,
  input logic             iterFlag,
  input logic [CNT_W-1:0] errCount
);

  // remembers whether the latest character came in with drive suppressed
  logic quietChar;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          quietChar <= 1'b0;
    else if (charValid) quietChar <= suppressNack;
  end

  p_quiet_r7: assert property (@(posedge clk) disable iff (!rstN)
    quietChar |-> !nackOe);

  p_inc_r2: assert property (@(posedge clk) disable iff (!rstN)
    (charValid && parityErr && !iterClr && errCount < maxIter)
      |=> errCount == $past(errCount) + CNT_W'(1));

  p_good_r4: assert property (@(posedge clk) disable iff (!rstN)
    (charValid && !parityErr) |=> errCount == '0);

  p_ceiling_r5: assert property (@(posedge clk) disable iff (!rstN)
    (charValid && parityErr && !iterClr && errCount >= maxIter) |=> iterFlag);

  p_bound_r5: assert property (@(posedge clk) disable iff (!rstN)
    errCount <= maxIter);

  p_sticky_r8: assert property (@(posedge clk) disable iff (!rstN)
    (iterFlag && !iterClr) |=> iterFlag);

  p_clear_r8: assert property (@(posedge clk) disable iff (!rstN)
    iterClr |=> (errCount == '0 && !iterFlag));

  p_rise_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(nackOe) |-> $past(halfTick));

  p_fall_r3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(nackOe) |-> $past(halfTick));

endmodule

bind parity_nack_ctl pnack_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .halfTick(halfTick), .charValid(charValid),
  .parityErr(parityErr), .maxIter(maxIter), .suppressNack(suppressNack),
  .iterClr(iterClr), .nackOe(nackOe), .iterFlag(iterFlag), .errCount(errCount)
);

// File: tb/sim_parity_nack_ctl.sv
module sim_parity_nack_ctl;
  timeunit 1ns;
  timeprecision 100ps;

  localparam int CNT_W = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic halfTick = 1'b0, charValid = 1'b0, parityErr = 1'b0;
  logic [CNT_W-1:0] maxIter = '0;
  logic suppressNack = 1'b0, iterClr = 1'b0;
  logic nackOe, iterFlag;
  logic [CNT_W-1:0] errCount;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  parity_nack_ctl #(.CNT_W(CNT_W)) u0 (
    .clk(clk), .rstN(rstN), .halfTick(halfTick), .charValid(charValid),
    .parityErr(parityErr), .maxIter(maxIter), .suppressNack(suppressNack),
    .iterClr(iterClr), .nackOe(nackOe), .iterFlag(iterFlag), .errCount(errCount)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulseTick();
    halfTick = 1'b1;
    @(negedge clk);
    halfTick = 1'b0;
  endtask

  task automatic sendChar(input logic bad, input logic withTick);
    charValid = 1'b1;
    parityErr = bad;
    halfTick  = withTick;
    @(negedge clk);
    charValid = 1'b0;
    parityErr = 1'b0;
    halfTick  = 1'b0;
  endtask

  // walks one refusal window: delay tick, two drive ticks
  task automatic nackWindow(input int exp, input string req);
    chk({req, " idle before delay tick"}, nackOe, 0);
    idle(2);
    chk({req, " still low before tick"}, nackOe, 0);
    pulseTick();
    chk({req, " drive after delay tick"}, nackOe, exp);
    idle(2);
    chk({req, " drive held"}, nackOe, exp);
    pulseTick();
    chk({req, " drive after first bit tick"}, nackOe, exp);
    idle(2);
    pulseTick();
    chk({req, " released after bit time"}, nackOe, 0);
    idle(1);
  endtask

  task automatic doClear();
    iterClr = 1'b1;
    @(negedge clk);
    iterClr = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 nackOe", nackOe, 0);
    chk("R1 iterFlag", iterFlag, 0);
    chk("R1 errCount", errCount, 0);
  endtask

  task automatic t_errNack();
    maxIter = 3'd3; suppressNack = 1'b0;
    sendChar(1'b1, 1'b0);
    chk("R2 count after error", errCount, 1);
    nackWindow(1, "R3");
  endtask

  task automatic t_goodReset();
    sendChar(1'b0, 1'b0);
    chk("R4 count cleared", errCount, 0);
    nackWindow(0, "R4 no refusal");
  endtask

  task automatic t_saturate();
    for (int i = 1; i <= 3; i++) begin
      sendChar(1'b1, 1'b0);
      chk("R2 count climbs", errCount, i);
      nackWindow(1, "R2 refused");
    end
    chk("R5 flag low at ceiling", iterFlag, 0);
    sendChar(1'b1, 1'b0);
    chk("R5 flag set", iterFlag, 1);
    chk("R5 count held", errCount, 3);
    nackWindow(0, "R5 no refusal");
    sendChar(1'b0, 1'b0);
    chk("R8 flag sticky", iterFlag, 1);
    chk("R4 count zero", errCount, 0);
    idle(3);
    chk("R8 flag still set", iterFlag, 1);
    doClear();
    chk("R8 flag cleared", iterFlag, 0);
  endtask

  task automatic t_zeroMax();
    maxIter = 3'd0;
    sendChar(1'b1, 1'b0);
    chk("R6 flag on first error", iterFlag, 1);
    chk("R6 count zero", errCount, 0);
    nackWindow(0, "R6 no refusal");
    doClear();
    maxIter = 3'd3;
  endtask

  task automatic t_suppress();
    suppressNack = 1'b1;
    sendChar(1'b1, 1'b0);
    chk("R7 count still climbs", errCount, 1);
    nackWindow(0, "R7 suppressed");
    suppressNack = 1'b0;
    doClear();
    chk("R8 count cleared", errCount, 0);
  endtask

  task automatic t_clrPriority();
    sendChar(1'b1, 1'b0);
    nackWindow(1, "R2 pre-clear");
    charValid = 1'b1; parityErr = 1'b1; iterClr = 1'b1;
    @(negedge clk);
    charValid = 1'b0; parityErr = 1'b0; iterClr = 1'b0;
    chk("R8 clear wins count", errCount, 0);
    chk("R8 clear wins flag", iterFlag, 0);
    nackWindow(0, "R8 discarded char");
  endtask

  task automatic t_sameTick();
    sendChar(1'b1, 1'b1);
    chk("R9 count", errCount, 1);
    chk("R9 coincident tick ignored", nackOe, 0);
    nackWindow(1, "R9");
    doClear();
  endtask

  initial begin
    idle(3);
    rstN = 1'b1;
    idle(2);
    t_reset();
    t_errNack();
    t_goodReset();
    t_saturate();
    t_zeroMax();
    t_suppress();
    t_clrPriority();
    t_sameTick();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule